// File: doc/BRIEF.md
# Memory Protection Register Bank

This block keeps the per-region settings of a physical memory protection unit with up to 64 regions. Every region has an 8-bit settings byte and an address word. Software reaches them through a single-cycle CSR port. The port takes an address, an operation (read, write, bit-set or bit-clear), write data, the current privilege level and a mode bit that picks a 32-bit or 64-bit register view. The block returns read data and an illegal-access flag in the same cycle as the request. Writes take effect at the next rising clock edge.

The settings bytes are packed densely into sixteen settings CSRs. In the 32-bit view each CSR holds four bytes. In the 64-bit view only the even-numbered CSRs exist, and each holds eight bytes. The address words live in sixty-four address CSRs. The unpacked bytes and address words are driven out continuously to a separate region-matching unit. The number of implemented regions is a parameter (0, 16 or 64), and the reset contents are parameters as well.

Top module: `pmp_csr_bank`

## Requirements
- R1: CSR numbers 0x3A0–0x3AF select settings CSR k = number − 0x3A0, and 0x3B0–0x3EF select address CSR i = number − 0x3B0. An access to any other number returns zero read data, does not raise the illegal flag and changes no state.
- R2: In the 32-bit view (`csr_xlen64`=0), settings CSR k returns the byte of region 4k+b in bits [8b+7:8b] for b = 0..3, and bits [63:32] read zero. A write updates exactly those four bytes from the matching write-data bytes.
- R3: In the 64-bit view, an even settings CSR k returns the bytes of regions 4k..4k+7 in bits [8b+7:8b] for b = 0..7. A write updates those eight bytes.
- R4: In the 64-bit view, any access to an odd settings CSR raises the illegal flag, returns zero and changes no state.
- R5: When `csr_priv` is not 2'b11 (machine level), an access to any CSR in 0x3A0–0x3EF raises the illegal flag, returns zero and changes no state.
- R6: Settings bits outside `CFG_LEGAL_MASK` (default 8'h9F, so bits 6:5) are always zero, both in read data and on `entry_cfg`.
- R7: An address CSR holds 54 bits. A 64-bit-view access reads bits [53:0] with bits [63:54] zero, and a write stores `wdata[53:0]`. A 32-bit-view access reads bits [31:0] with the upper bits zero, and a write stores `wdata[31:0]` and clears bits [53:32].
- R8: `csr_op` encodes 0 = read only, 1 = write, 2 = set (old OR data), 3 = clear (old AND NOT data). Read data shows the value before the update, and the stored value changes at the next rising edge.
- R9: CSRs and bytes that belong to regions at or above `NUM_ENTRIES` read as zero and ignore writes, without raising the illegal flag.
- R10: After reset, region e holds `CFG_RESET[8e+7:8e]` masked by `CFG_LEGAL_MASK` and holds `ADDR_RESET[54e+53:54e]`.
- R11: `entry_cfg[8e+7:8e]` and `entry_addr[54e+53:54e]` always show the stored byte and address word of region e.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_valid | input | 1 | An access is presented this cycle |
| csr_addr | input | 12 | CSR number |
| csr_op | input | 2 | 0 read, 1 write, 2 set, 3 clear |
| csr_wdata | input | 64 | Write or mask data |
| csr_priv | input | 2 | Current privilege level, 2'b11 is machine |
| csr_xlen64 | input | 1 | 1 selects the 64-bit register view |
| csr_rdata | output | 64 | Read data, combinational |
| csr_illegal | output | 1 | Illegal access, combinational |
| entry_cfg | output | 8·max(NUM_ENTRIES,1) | Unpacked settings bytes, region 0 lowest |
| entry_addr | output | 54·max(NUM_ENTRIES,1) | Unpacked address words, region 0 lowest |

## Verification
Read data and the illegal flag depend only on the request and the stored state, so they are due in the cycle of the request. The bench samples them one nanosecond after it drives the inputs on a falling edge, before the next rising edge. The stored bytes and address words change at that rising edge. The bench therefore compares `entry_cfg` and `entry_addr` with its model at the following falling edge, once the request has been withdrawn. It also updates its model between the two samples, so each sample is compared against the state it should see.

// File: rtl/pmp_bank_pkg.sv
`timescale 1ns/1ps
package pmp_bank_pkg;
   localparam int MAX_ENTRIES = 64;
   localparam int ADDR_BITS   = 54;
   localparam int DATA_BITS   = 64;
   localparam logic [11:0] CFG_FIRST  = 12'h3A0;
   localparam logic [11:0] CFG_LAST   = 12'h3AF;
   localparam logic [11:0] ADDR_FIRST = 12'h3B0;
   localparam logic [11:0] ADDR_LAST  = 12'h3EF;
   localparam logic [1:0]  PRIV_MACH  = 2'b11;

   typedef enum logic [1:0] {
      OP_READ  = 2'd0,
      OP_WRITE = 2'd1,
      OP_SET   = 2'd2,
      OP_CLEAR = 2'd3
   } csr_op_e;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_CFG  = 2'd1,
      SEL_ADDR = 2'd2
   } sel_e;

   typedef struct packed {
      sel_e       sel;
      logic [5:0] idx;
      logic       illegal;
   } dec_t;

   // read-modify-write combine for one CSR operation
   function automatic logic [DATA_BITS-1:0] apply_op(csr_op_e op,
                                                     logic [DATA_BITS-1:0] old_v,
                                                     logic [DATA_BITS-1:0] wd);
      case (op)
         OP_WRITE: return wd;
         OP_SET:   return old_v | wd;
         OP_CLEAR: return old_v & ~wd;
         default:  return old_v;
      endcase
   endfunction
endpackage

// File: rtl/pmp_csr_decode.sv
`timescale 1ns/1ps
module pmp_csr_decode
   import pmp_bank_pkg::*;
(
   input  logic        valid,
   input  logic [11:0] addr,
   input  logic [1:0]  priv,
   input  logic        xlen64,
   output dec_t        dec
);
   logic in_cfg, in_addr;

   always_comb begin
      in_cfg  = (addr >= CFG_FIRST)  && (addr <= CFG_LAST);
      in_addr = (addr >= ADDR_FIRST) && (addr <= ADDR_LAST);
      dec.sel = SEL_NONE;
      dec.idx = '0;
      if (in_cfg) begin
         dec.sel = SEL_CFG;
         dec.idx = {2'b00, addr[3:0]};
      end else if (in_addr) begin
         dec.sel = SEL_ADDR;
         dec.idx = 6'(addr - ADDR_FIRST);
      end
      dec.illegal = valid && (in_cfg || in_addr) &&
                    ((priv != PRIV_MACH) || (xlen64 && in_cfg && addr[0]));
   end
endmodule

// File: rtl/pmp_entry_reg.sv
`timescale 1ns/1ps
module pmp_entry_reg #(
   parameter int          ABITS    = 54,
   parameter logic [7:0]  CFG_MASK = 8'h9F,
   parameter logic [7:0]  CFG_RST  = 8'h00,
   parameter logic [ABITS-1:0] ADDR_RST = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [7:0]       cfg_d,
   input  logic             addr_we,
   input  logic [ABITS-1:0] addr_d,
   output logic [7:0]       cfg_q,
   output logic [ABITS-1:0] addr_q
);
   localparam logic [7:0] CFG_RST_LEGAL = CFG_RST & CFG_MASK;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= CFG_RST_LEGAL;
         addr_q <= ADDR_RST;
      end else begin
         if (cfg_we)  cfg_q  <= cfg_d & CFG_MASK;
         if (addr_we) addr_q <= addr_d;
      end
   end
endmodule

// File: rtl/pmp_csr_bank.sv
`timescale 1ns/1ps
module pmp_csr_bank
   import pmp_bank_pkg::*;
#(
   parameter int         NUM_ENTRIES    = 16,
   parameter logic [7:0] CFG_LEGAL_MASK = 8'h9F,
   parameter logic [MAX_ENTRIES*8-1:0]         CFG_RESET  = '0,
   parameter logic [MAX_ENTRIES*ADDR_BITS-1:0] ADDR_RESET = '0,
   localparam int ENT_W = (NUM_ENTRIES == 0) ? 1 : NUM_ENTRIES
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   csr_valid,
   input  logic [11:0]            csr_addr,
   input  logic [1:0]             csr_op,
   input  logic [63:0]            csr_wdata,
   input  logic [1:0]             csr_priv,
   input  logic                   csr_xlen64,
   output logic [63:0]            csr_rdata,
   output logic                   csr_illegal,
   output logic [ENT_W*8-1:0]     entry_cfg,
   output logic [ENT_W*ADDR_BITS-1:0] entry_addr
);
   if (!(NUM_ENTRIES == 0 || NUM_ENTRIES == 16 || NUM_ENTRIES == 64)) begin : g_bad_count
      $error("pmp_csr_bank: NUM_ENTRIES must be 0, 16 or 64");
   end

   dec_t    dec;
   csr_op_e op_e;
   logic    wr_en;
   logic [6:0] nbytes;
   logic [6:0] cfg_base;
   logic [MAX_ENTRIES*8-1:0]         cfg_flat;
   logic [MAX_ENTRIES*ADDR_BITS-1:0] addr_flat;

   pmp_csr_decode i_dec (
      .valid  (csr_valid),
      .addr   (csr_addr),
      .priv   (csr_priv),
      .xlen64 (csr_xlen64),
      .dec    (dec)
   );

   assign op_e     = csr_op_e'(csr_op);
   assign wr_en    = csr_valid && !dec.illegal && (op_e != OP_READ);
   assign nbytes   = csr_xlen64 ? 7'd8 : 7'd4;
   assign cfg_base = {dec.idx[4:0], 2'b00};
   assign csr_illegal = dec.illegal;

   for (genvar e = 0; e < MAX_ENTRIES; e++) begin : g_ent
      if (e < NUM_ENTRIES) begin : g_impl
         logic [6:0]           rel;
         logic                 hit_cfg, hit_addr;
         logic [7:0]           wbyte, cfg_d, cfg_q;
         logic [ADDR_BITS-1:0] addr_raw, addr_d, addr_q;

         always_comb begin
            rel      = 7'(e) - cfg_base;
            hit_cfg  = wr_en && (dec.sel == SEL_CFG) &&
                       (7'(e) >= cfg_base) && (rel < nbytes);
            wbyte    = 8'(csr_wdata >> {rel[2:0], 3'b000});
            cfg_d    = 8'(apply_op(op_e, {56'b0, cfg_q}, {56'b0, wbyte}));
            hit_addr = wr_en && (dec.sel == SEL_ADDR) && (dec.idx == 6'(e));
            addr_raw = ADDR_BITS'(apply_op(op_e, {10'b0, addr_q}, csr_wdata));
            addr_d   = csr_xlen64 ? addr_raw : {22'b0, addr_raw[31:0]};
         end

         pmp_entry_reg #(
            .ABITS    (ADDR_BITS),
            .CFG_MASK (CFG_LEGAL_MASK),
            .CFG_RST  (CFG_RESET[8*e +: 8]),
            .ADDR_RST (ADDR_RESET[ADDR_BITS*e +: ADDR_BITS])
         ) i_reg (
            .clk     (clk),
            .rst_n   (rst_n),
            .cfg_we  (hit_cfg),
            .cfg_d   (cfg_d),
            .addr_we (hit_addr),
            .addr_d  (addr_d),
            .cfg_q   (cfg_q),
            .addr_q  (addr_q)
         );

         assign cfg_flat[8*e +: 8]                     = cfg_q;
         assign addr_flat[ADDR_BITS*e +: ADDR_BITS]    = addr_q;
      end else begin : g_absent
         assign cfg_flat[8*e +: 8]                     = 8'h00;
         assign addr_flat[ADDR_BITS*e +: ADDR_BITS]    = '0;
      end
   end

   if (NUM_ENTRIES == 0) begin : g_out_none
      assign entry_cfg  = '0;
      assign entry_addr = '0;
   end else begin : g_out
      assign entry_cfg  = cfg_flat[NUM_ENTRIES*8-1:0];
      assign entry_addr = addr_flat[NUM_ENTRIES*ADDR_BITS-1:0];
   end

   // packed read image, combinational
   always_comb begin
      int ent;
      logic [ADDR_BITS-1:0] aw;
      csr_rdata = '0;
      aw        = '0;
      ent       = 0;
      if (csr_valid && !dec.illegal) begin
         case (dec.sel)
            SEL_CFG: begin
               for (int b = 0; b < 8; b++) begin
                  ent = int'(cfg_base) + b;
                  if ((b < 4 || csr_xlen64) && ent < MAX_ENTRIES)
                     csr_rdata[8*b +: 8] = cfg_flat[8*ent +: 8];
               end
            end
            SEL_ADDR: begin
               aw = addr_flat[ADDR_BITS*int'(dec.idx) +: ADDR_BITS];
               csr_rdata = csr_xlen64 ? {10'b0, aw} : {32'b0, aw[31:0]};
            end
            default: csr_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/pmp_csr_bank_chk.sv
`timescale 1ns/1ps
module pmp_csr_bank_chk #(
   parameter int         NUM_ENTRIES    = 16,
   parameter logic [7:0] CFG_LEGAL_MASK = 8'h9F,
   localparam int ENT_W = (NUM_ENTRIES == 0) ? 1 : NUM_ENTRIES
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 csr_valid,
   input logic [11:0]          csr_addr,
   input logic [1:0]           csr_op,
   input logic [1:0]           csr_priv,
   input logic                 csr_xlen64,
   input logic [63:0]          csr_rdata,
   input logic                 csr_illegal,
   input logic [ENT_W*8-1:0]   entry_cfg,
   input logic [ENT_W*54-1:0]  entry_addr
);
   logic in_range, in_cfg, in_addr;
   assign in_range = (csr_addr >= 12'h3A0) && (csr_addr <= 12'h3EF);
   assign in_cfg   = (csr_addr[11:4] == 8'h3A);
   assign in_addr  = in_range && !in_cfg;

   AST_OUT_OF_MAP: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_valid && !in_range) |-> (!csr_illegal && csr_rdata == 64'd0)); // R1
   AST_RD32_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_valid && !csr_xlen64) |-> (csr_rdata[63:32] == 32'd0)); // R2
   AST_ODD_CFG_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_valid && csr_xlen64 && in_cfg && csr_addr[0]) |-> csr_illegal); // R4
   AST_ILLEGAL_NO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
      csr_illegal |=> ($stable(entry_cfg) && $stable(entry_addr))); // R4
   AST_LOW_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_valid && in_range && csr_priv != 2'b11) |-> csr_illegal); // R5
   AST_ILLEGAL_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      csr_illegal |-> (csr_rdata == 64'd0)); // R5
   AST_ADDR_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_valid && csr_xlen64 && in_addr) |-> (csr_rdata[63:54] == 10'd0)); // R7
   AST_READ_ONLY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!csr_valid || csr_op == 2'd0) |=> ($stable(entry_cfg) && $stable(entry_addr))); // R8

   for (genvar e = 0; e < ENT_W; e++) begin : g_legal
      AST_CFG_LEGAL_BITS: assert property (@(posedge clk) disable iff (!rst_n)
         ((entry_cfg[8*e +: 8] & ~CFG_LEGAL_MASK) == 8'h00)); // R6
   end
endmodule

bind pmp_csr_bank pmp_csr_bank_chk #(
   .NUM_ENTRIES    (NUM_ENTRIES),
   .CFG_LEGAL_MASK (CFG_LEGAL_MASK)
) i_chk (.*);

// File: tb/test_pmp_csr_bank.sv
`timescale 1ns/1ps
module test_pmp_csr_bank;
   localparam int         N    = 16;
   localparam logic [7:0] MASK = 8'h9F;
   localparam logic [511:0]  TB_CFG_RST  = (512'hFF) | (512'h1A << 40);
   localparam logic [3455:0] TB_ADDR_RST = 3456'(54'h0ABCDEF0123456) << 54;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        csr_valid = 1'b0;
   logic [11:0] csr_addr = '0;
   logic [1:0]  csr_op = '0;
   logic [63:0] csr_wdata = '0;
   logic [1:0]  csr_priv = 2'b11;
   logic        csr_xlen64 = 1'b0;
   logic [63:0] csr_rdata;
   logic        csr_illegal;
   logic [N*8-1:0]  entry_cfg;
   logic [N*54-1:0] entry_addr;

   int nchk = 0;
   int nfail = 0;
   logic [7:0]  m_cfg [N];
   logic [53:0] m_addr[N];

   always #2 clk = ~clk;

   pmp_csr_bank #(
      .NUM_ENTRIES    (N),
      .CFG_LEGAL_MASK (MASK),
      .CFG_RESET      (TB_CFG_RST),
      .ADDR_RESET     (TB_ADDR_RST)
   ) i_pmp_csr_bank (.*);

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic logic [63:0] op_f(input logic [1:0] op, input logic [63:0] o,
                                        input logic [63:0] w);
      case (op)
         2'd1: return w;
         2'd2: return o | w;
         2'd3: return o & ~w;
         default: return o;
      endcase
   endfunction

   function automatic logic exp_ill(input logic [11:0] a, input logic [1:0] pr,
                                    input logic x64);
      logic inr = (a >= 12'h3A0) && (a <= 12'h3EF);
      return inr && ((pr != 2'b11) || (x64 && a <= 12'h3AF && a[0]));
   endfunction

   function automatic logic [63:0] exp_rd(input logic [11:0] a, input logic [1:0] pr,
                                          input logic x64);
      logic [63:0] r = '0;
      if (exp_ill(a, pr, x64)) return r;
      if (a >= 12'h3A0 && a <= 12'h3AF) begin
         for (int b = 0; b < (x64 ? 8 : 4); b++) begin
            int e = 4 * int'(a - 12'h3A0) + b;
            if (e < N) r[8*b +: 8] = m_cfg[e];
         end
      end else if (a >= 12'h3B0 && a <= 12'h3EF) begin
         int i = int'(a - 12'h3B0);
         if (i < N) r = x64 ? {10'b0, m_addr[i]} : {32'b0, m_addr[i][31:0]};
      end
      return r;
   endfunction

   task automatic model_upd(input logic [11:0] a, input logic [1:0] op,
                            input logic [63:0] wd, input logic [1:0] pr, input logic x64);
      if (exp_ill(a, pr, x64) || op == 2'd0) return;
      if (a >= 12'h3A0 && a <= 12'h3AF) begin
         for (int b = 0; b < (x64 ? 8 : 4); b++) begin
            int e = 4 * int'(a - 12'h3A0) + b;
            if (e < N) m_cfg[e] = 8'(op_f(op, {56'b0, m_cfg[e]}, {56'b0, wd[8*b +: 8]})) & MASK;
         end
      end else if (a >= 12'h3B0 && a <= 12'h3EF) begin
         int i = int'(a - 12'h3B0);
         if (i < N) begin
            logic [63:0] v = op_f(op, {10'b0, m_addr[i]}, wd);
            m_addr[i] = x64 ? v[53:0] : {22'b0, v[31:0]};
         end
      end
   endtask

   task automatic check_outputs(input string tag);
      bit bad = 0;
      int first = 0;
      for (int e = 0; e < N; e++) begin
         if (!bad && (entry_cfg[8*e +: 8] !== m_cfg[e] || entry_addr[54*e +: 54] !== m_addr[e])) begin
            bad = 1;
            first = e;
         end
      end
      chk(!bad, tag, $sformatf("region %0d outputs (cfg, addr shown)", first),
          {2'b0, entry_cfg[8*first +: 8], entry_addr[54*first +: 54]},
          {2'b0, m_cfg[first], m_addr[first]});
   endtask

   task automatic access(input logic [11:0] a, input logic [1:0] op, input logic [63:0] wd,
                         input logic [1:0] pr, input logic x64, input string tag);
      logic [63:0] er;
      logic        ei;
      @(negedge clk);
      csr_valid = 1'b1; csr_addr = a; csr_op = op; csr_wdata = wd;
      csr_priv = pr; csr_xlen64 = x64;
      #1;
      er = exp_rd(a, pr, x64);
      ei = exp_ill(a, pr, x64);
      chk(csr_rdata === er, tag, $sformatf("rdata @%h", a), csr_rdata, er);
      chk(csr_illegal === ei, tag, $sformatf("illegal @%h", a), {63'b0, csr_illegal}, {63'b0, ei});
      model_upd(a, op, wd, pr, x64);
      @(negedge clk);
      csr_valid = 1'b0; csr_op = 2'd0;
      #1;
      check_outputs({tag, " R11"});
   endtask

   function automatic string rand_tag(input logic [11:0] a, input logic [1:0] pr,
                                      input logic x64);
      if (a < 12'h3A0 || a > 12'h3EF) return "R1";
      if (pr != 2'b11) return "R5";
      if (a <= 12'h3AF) begin
         if (x64 && a[0]) return "R4";
         if (4 * int'(a - 12'h3A0) >= N) return "R9";
         return x64 ? "R3" : "R2";
      end
      return (int'(a - 12'h3B0) >= N) ? "R9" : "R7";
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      void'($urandom(32'd7));
      for (int e = 0; e < N; e++) begin
         m_cfg[e]  = TB_CFG_RST[8*e +: 8] & MASK;
         m_addr[e] = TB_ADDR_RST[54*e +: 54];
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check_outputs("R10");
      chk(entry_cfg[7:0] === 8'h9F, "R10 R6", "reset byte 0", {56'b0, entry_cfg[7:0]}, 64'h9F);
      access(12'h3A0, 2'd0, 64'h0, 2'b11, 1'b0, "R10 R2");
      // reserved settings bits
      access(12'h3A0, 2'd1, 64'hFFFF_FFFF_FFFF_FFFF, 2'b11, 1'b0, "R6");
      access(12'h3A0, 2'd0, 64'h0, 2'b11, 1'b0, "R6");
      // set then clear, read-only op keeps state
      access(12'h3A1, 2'd1, 64'h0000_0000_0102_0304, 2'b11, 1'b0, "R8");
      access(12'h3A1, 2'd2, 64'h0000_0000_8010_0000, 2'b11, 1'b0, "R8");
      access(12'h3A1, 2'd3, 64'h0000_0000_0002_0001, 2'b11, 1'b0, "R8");
      access(12'h3A1, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 2'b11, 1'b0, "R8");
      // wide view packing
      access(12'h3A2, 2'd1, 64'h8807_0605_0403_0201, 2'b11, 1'b1, "R3");
      access(12'h3A2, 2'd0, 64'h0, 2'b11, 1'b0, "R2");
      access(12'h3A3, 2'd0, 64'h0, 2'b11, 1'b0, "R2");
      access(12'h3A3, 2'd1, 64'h1111_1111_1111_1111, 2'b11, 1'b1, "R4");
      access(12'h3A5, 2'd0, 64'h0, 2'b11, 1'b1, "R4");
      // privilege
      access(12'h3B2, 2'd1, 64'h1234, 2'b01, 1'b0, "R5");
      access(12'h3A0, 2'd1, 64'h0, 2'b00, 1'b1, "R5");
      // unimplemented regions
      access(12'h3A4, 2'd1, 64'hFFFF_FFFF_FFFF_FFFF, 2'b11, 1'b1, "R9");
      access(12'h3C4, 2'd1, 64'hFFFF_FFFF_FFFF_FFFF, 2'b11, 1'b1, "R9");
      access(12'h3C4, 2'd0, 64'h0, 2'b11, 1'b1, "R9");
      // outside the map
      access(12'h3F0, 2'd1, 64'hFFFF, 2'b11, 1'b0, "R1");
      access(12'h39F, 2'd1, 64'hFFFF, 2'b01, 1'b1, "R1");
      // address width per view
      access(12'h3B3, 2'd1, 64'hFFFF_FFFF_FFFF_FFFF, 2'b11, 1'b1, "R7");
      access(12'h3B3, 2'd0, 64'h0, 2'b11, 1'b1, "R7");
      access(12'h3B3, 2'd2, 64'h0000_0000_0000_0001, 2'b11, 1'b0, "R7");
      access(12'h3B3, 2'd0, 64'h0, 2'b11, 1'b1, "R7");
      access(12'h3B1, 2'd0, 64'h0, 2'b11, 1'b1, "R10 R7");

      for (int it = 0; it < 400; it++) begin
         logic [11:0] a;
         logic [1:0]  pr;
         logic        x64;
         int          k = int'($urandom % 10);
         if (k < 4)       a = 12'h3A0 + 12'($urandom % 16);
         else if (k < 8)  a = 12'h3B0 + 12'($urandom % 64);
         else if (k == 8) a = 12'h3F0 + 12'($urandom % 16);
         else             a = 12'h390 + 12'($urandom % 16);
         pr  = ($urandom % 8 == 0) ? 2'($urandom % 3) : 2'b11;
         x64 = 1'($urandom);
         access(a, 2'($urandom), {$urandom, $urandom}, pr, x64, rand_tag(a, pr, x64));
      end

      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end
endmodule